// File: doc/BRIEF.md
# Programmable Logic Cell Array

This block is a ring of four small programmable logic cells that evaluate user-defined Boolean functions with no processor in the loop. Each cell has two source selectors and an 8-bit function value. The selectors pick from a 16-entry source bus that carries the cells' own outputs and twelve external signals, such as pins or timer and capture pulses. The function value defines the cell's truth table. The third table input is a carry taken from the table output of the neighbouring cell, and the chain closes on itself. Each cell can present either its raw table result or a registered copy of it. Every cell output also leaves the block through a two-stage synchroniser so that downstream logic sees clean values.

The register in each cell lives in the system-clock domain. The "clock" that software selects for a cell is sampled there: its chosen edge becomes a one-cycle capture strobe. Software configures the array through a plain write-only port that takes an address, data and a write strobe. The port carries single configuration writes rather than a data stream, so it has no valid/ready handshake and never applies back-pressure. A write is always accepted on the edge where the strobe is high. When a cell presents its raw table result, its output may feed back into its own selectors. This lets latches be built from the table alone, for example a set/reset latch.

Top module: `clu_array`

## Requirements
- R1: The table output of a cell is bit `{A,B,C}` of its function value, where A (selector A) is the most significant index bit and C (carry) the least. For example A=1, B=1, C=1 selects bit 7 and A=0, B=0, C=0 selects bit 0.
- R2: Selector code s in 0..3 picks the output of cell s. Code s in 4..15 picks `ext_i[s-4]`.
- R3: The carry of cell n is the gated table output of cell n-1, and cell 0 takes its carry from cell 3.
- R4: Control bit 1 (bypass) set makes the cell output the current table result. When it is clear, the cell outputs its register, which lags the table by the capture strobe.
- R5: Control bits 4:3 choose the capture strobe: 0 every system clock, 1 an edge of selector A, 2 an edge of `ext_clk_i`, 3 an edge of the carry. Control bit 2 picks the edge: 0 rising, 1 falling. It has no effect for code 0.
- R6: While control bit 0 (enable) is 0, the cell's output, its carry contribution and its register are 0.
- R7: While control bit 5 (clear) is 1 in an enabled cell, the register becomes 0 at the next system-clock edge.
- R8: `cell_sync_o` equals `cell_async_o` delayed by exactly two system-clock edges.
- R9: A write with `cfg_addr_i[3:2]` = cell and `cfg_addr_i[1:0]` = register updates that register at the clock edge where `cfg_we_i` is high. The registers are: 0 function value (8 bits), 1 selector A (low 4 bits), 2 selector B (low 4 bits), 3 control (low 6 bits).
- R10: Synchronous reset clears all configuration and all flip-flops, so both output vectors are 0.
- R11: A bypassed cell with function value 0x74 acts as a set/reset latch when A is the set signal, B is its own output and C is the reset signal. It holds when both are 0, reads 0 on reset alone and 1 on set alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ext_i | input | 12 | External sources, selector codes 4..15 |
| ext_clk_i | input | 1 | Alternate capture clock, sampled by the system clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Cell index in bits 3:2, register index in bits 1:0 |
| cfg_wdata_i | input | 8 | Configuration write data |
| cell_async_o | output | 4 | Direct cell outputs, also on the source bus |
| cell_sync_o | output | 4 | Cell outputs after the two-stage synchroniser |

## Verification
The hardest state to reach from the ports is a cell whose output holds only through its own combinational feedback. To get there, the bench first fills in a neighbour so that it forwards a reset pin into the carry. It then points the target cell's B selector at the cell's own output and enables the cell last, so that no half-configured loop ever becomes active. After that it walks set, hold and reset sequences. Edge-selected capture is driven by toggling `ext_clk_i` while the table value is already different from the register. This shows that only the chosen edge moves the register and that the other edge and idle cycles leave it alone.

// File: rtl/clu_pkg.sv
package clu_pkg;

  localparam int LUT_IN   = 3;
  localparam int FN_W     = 1 << LUT_IN;
  localparam int REG_IDX_W = 2;
  localparam int CTRL_W   = 6;

  typedef enum logic [1:0] {
    CLK_SYS   = 2'd0,
    CLK_SELA  = 2'd1,
    CLK_EXT   = 2'd2,
    CLK_CARRY = 2'd3
  } clk_src_e;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_FN   = 2'd0,
    REG_SELA = 2'd1,
    REG_SELB = 2'd2,
    REG_CTRL = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic     ff_clr;
    clk_src_e clk_sel;
    logic     clk_fall;
    logic     bypass;
    logic     enable;
  } cell_ctrl_t;

endpackage

// File: rtl/clu_cfg_regs.sv
module clu_cfg_regs
  import clu_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 8,
  localparam int CELL_W   = $clog2(NUM_CELLS),
  localparam int ADDR_W   = CELL_W + REG_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [FN_W-1:0]   fn_o   [NUM_CELLS],
  output logic [SEL_W-1:0]  sela_o [NUM_CELLS],
  output logic [SEL_W-1:0]  selb_o [NUM_CELLS],
  output cell_ctrl_t        ctrl_o [NUM_CELLS]
);

  logic [CELL_W-1:0] cell_idx;
  reg_idx_e          reg_idx;

  assign cell_idx = addr_i[ADDR_W-1:REG_IDX_W];
  assign reg_idx  = reg_idx_e'(addr_i[REG_IDX_W-1:0]);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell_regs
    logic hit;
    assign hit = we_i && (cell_idx == CELL_W'(c));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        fn_o[c]   <= '0;
        sela_o[c] <= '0;
        selb_o[c] <= '0;
        ctrl_o[c] <= '0;
      end else if (hit) begin
        case (reg_idx)
          REG_FN:   fn_o[c]   <= wdata_i[FN_W-1:0];
          REG_SELA: sela_o[c] <= wdata_i[SEL_W-1:0];
          REG_SELB: selb_o[c] <= wdata_i[SEL_W-1:0];
          REG_CTRL: ctrl_o[c] <= cell_ctrl_t'(wdata_i[CTRL_W-1:0]);
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/clu_cell.sv
module clu_cell
  import clu_pkg::*;
#(
  parameter int SEL_W   = 4,
  localparam int NUM_SRC = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               carry_i,
  input  logic               ext_clk_i,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [SEL_W-1:0]   sela_i,
  input  logic [SEL_W-1:0]   selb_i,
  input  cell_ctrl_t         ctrl_i,
  output logic               lut_o,
  output logic               async_o,
  output logic               ff_q_o
);

  logic              in_a;
  logic              in_b;
  logic [LUT_IN-1:0] lut_idx;
  logic              lut_raw;
  logic              edge_src;
  logic              edge_prev;
  logic              cap_tick;
  logic              ff_q;

  // Selectors and truth table
  assign in_a    = src_i[sela_i];
  assign in_b    = src_i[selb_i];
  assign lut_idx = {in_a, in_b, carry_i};
  assign lut_raw = fn_i[lut_idx];
  assign lut_o   = ctrl_i.enable & lut_raw;

  // Capture strobe source, sampled in the system-clock domain
  always_comb begin
    case (ctrl_i.clk_sel)
      CLK_SELA:  edge_src = in_a;
      CLK_EXT:   edge_src = ext_clk_i;
      CLK_CARRY: edge_src = carry_i;
      default:   edge_src = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) edge_prev <= 1'b0;
    else       edge_prev <= edge_src;
  end

  always_comb begin
    if (ctrl_i.clk_sel == CLK_SYS)
      cap_tick = 1'b1;
    else if (ctrl_i.clk_fall)
      cap_tick = edge_prev & ~edge_src;
    else
      cap_tick = ~edge_prev & edge_src;
  end

  // Cell register
  always_ff @(posedge clk_i) begin
    if (rst_i || !ctrl_i.enable || ctrl_i.ff_clr)
      ff_q <= 1'b0;
    else if (cap_tick)
      ff_q <= lut_raw;
  end

  assign ff_q_o  = ff_q;
  assign async_o = ctrl_i.enable & (ctrl_i.bypass ? lut_raw : ff_q);

endmodule

// File: rtl/clu_sync.sv
module clu_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i)       stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clu_array.sv
module clu_array
  import clu_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 8,
  localparam int NUM_SRC  = 1 << SEL_W,
  localparam int EXT_W    = NUM_SRC - NUM_CELLS,
  localparam int CELL_W   = $clog2(NUM_CELLS),
  localparam int ADDR_W   = CELL_W + REG_IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [EXT_W-1:0]     ext_i,
  input  logic                 ext_clk_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  output logic [NUM_CELLS-1:0] cell_async_o,
  output logic [NUM_CELLS-1:0] cell_sync_o
);

  logic [FN_W-1:0]      fn_r   [NUM_CELLS];
  logic [SEL_W-1:0]     sela_r [NUM_CELLS];
  logic [SEL_W-1:0]     selb_r [NUM_CELLS];
  cell_ctrl_t           ctrl_r [NUM_CELLS];

  logic [NUM_CELLS-1:0] async_w;
  logic [NUM_CELLS-1:0] lut_w;
  logic [NUM_CELLS-1:0] ffq_w;
  logic [NUM_CELLS-1:0] en_v;
  logic [NUM_CELLS-1:0] clr_v;
  logic [NUM_CELLS-1:0] sysck_v;
  logic [NUM_SRC-1:0]   src_bus;

  clu_cfg_regs #(
    .NUM_CELLS (NUM_CELLS),
    .SEL_W     (SEL_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .fn_o    (fn_r),
    .sela_o  (sela_r),
    .selb_o  (selb_r),
    .ctrl_o  (ctrl_r)
  );

  // Low codes are cell outputs, the rest external sources
  assign src_bus = {ext_i, async_w};

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam int PREV = (i + NUM_CELLS - 1) % NUM_CELLS;

    clu_cell #(
      .SEL_W (SEL_W)
    ) u_cell (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .src_i     (src_bus),
      .carry_i   (lut_w[PREV]),
      .ext_clk_i (ext_clk_i),
      .fn_i      (fn_r[i]),
      .sela_i    (sela_r[i]),
      .selb_i    (selb_r[i]),
      .ctrl_i    (ctrl_r[i]),
      .lut_o     (lut_w[i]),
      .async_o   (async_w[i]),
      .ff_q_o    (ffq_w[i])
    );

    assign en_v[i]    = ctrl_r[i].enable;
    assign clr_v[i]   = ctrl_r[i].ff_clr;
    assign sysck_v[i] = (ctrl_r[i].clk_sel == CLK_SYS);
  end

  clu_sync #(
    .WIDTH  (NUM_CELLS),
    .STAGES (2)
  ) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (async_w),
    .q_o   (cell_sync_o)
  );

  assign cell_async_o = async_w;

endmodule

// File: rtl/clu_array_checker.sv
module clu_array_checker #(
  parameter int NUM_CELLS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CELLS-1:0] en,
  input logic [NUM_CELLS-1:0] clr,
  input logic [NUM_CELLS-1:0] sysck,
  input logic [NUM_CELLS-1:0] lut,
  input logic [NUM_CELLS-1:0] ffq,
  input logic [NUM_CELLS-1:0] async_o,
  input logic [NUM_CELLS-1:0] sync_o
);

  // R8: synchroniser lag is exactly two edges
  a_r8_sync_lag: assert property (@(posedge clk) disable iff (rst)
    sync_o == $past(async_o, 2));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
    // R6: a disabled cell leaves its register at 0
    a_r6_disabled_ff_zero: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> !ffq[i]);

    // R7: clear empties the register at the next edge
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
      (en[i] && clr[i]) |=> !ffq[i]);

    // R5: system-clock strobe captures the table every edge
    a_r5_sysclk_capture: assert property (@(posedge clk) disable iff (rst)
      (en[i] && !clr[i] && sysck[i]) |=> (ffq[i] == $past(lut[i])));
  end

endmodule

bind clu_array clu_array_checker #(.NUM_CELLS(NUM_CELLS)) u_clu_array_checker (
  .clk     (clk_i),
  .rst     (rst_i),
  .en      (en_v),
  .clr     (clr_v),
  .sysck   (sysck_v),
  .lut     (lut_w),
  .ffq     (ffq_w),
  .async_o (cell_async_o),
  .sync_o  (cell_sync_o)
);

// File: tb/clu_array_bench.sv
module clu_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {function value, {A,B,C}, expected table output}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h80, 3'b111, 1'b1},
    {8'h80, 3'b110, 1'b0},
    {8'h01, 3'b000, 1'b1},
    {8'h01, 3'b100, 1'b0},
    {8'h10, 3'b100, 1'b1},
    {8'h04, 3'b010, 1'b1},
    {8'h02, 3'b001, 1'b1},
    {8'hE8, 3'b011, 1'b1},
    {8'hE8, 3'b100, 1'b0},
    {8'h96, 3'b101, 1'b0},
    {8'h96, 3'b111, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ext = '0;
  logic        ext_clk = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  async_o;
  logic [3:0]  sync_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clu_array u_clu_array (
    .clk_i        (clk),
    .rst_i        (rst),
    .ext_i        (ext),
    .ext_clk_i    (ext_clk),
    .cfg_we_i     (we),
    .cfg_addr_i   (addr),
    .cfg_wdata_i  (wdata),
    .cell_async_o (async_o),
    .cell_sync_o  (sync_o)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ticks(3);
    check("R10 reset async", async_o, 4'b0000);
    check("R10 reset sync", sync_o, 4'b0000);
    rst = 1'b0;
    ticks(1);

    // Table walk: cell 0 A=ext0(code 4), B=ext1(code 5); carry from cell 3 forwarding ext2
    wr(4'd13, 8'd6);       // cell 3 selector A = code 6
    wr(4'd12, 8'hF0);      // cell 3 function: buffer of A
    wr(4'd15, 8'h03);      // cell 3 enable + bypass
    wr(4'd1, 8'd4);
    wr(4'd2, 8'd5);
    wr(4'd3, 8'h03);
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd0, VEC[v][11:4]);
      ext[0] = VEC[v][3];
      ext[1] = VEC[v][2];
      ext[2] = VEC[v][1];
      #1;
      check("R1 R3 table output", {3'b000, async_o[0]}, {3'b000, VEC[v][0]});
      ticks(2);
      check("R8 table sync", {3'b000, sync_o[0]}, {3'b000, VEC[v][0]});
    end

    // R2 R9: cell 2 selector A = code 15 -> ext[11]
    ext = '0;
    wr(4'd9, 8'd15);
    wr(4'd8, 8'hF0);
    wr(4'd11, 8'h03);
    ext[11] = 1'b1; #1;
    check("R2 R9 code 15 high", {3'b000, async_o[2]}, 4'b0001);
    ext[11] = 1'b0; #1;
    check("R2 code 15 low", {3'b000, async_o[2]}, 4'b0000);
    wr(4'd11, 8'h00);
    wr(4'd15, 8'h00);

    // R8 exact lag
    wr(4'd0, 8'h00);
    ticks(2);
    wr(4'd0, 8'hFF);       // async rises at this write edge
    check("R8 lag edge0 async", {3'b000, async_o[0]}, 4'b0001);
    check("R8 lag edge0 sync", {3'b000, sync_o[0]}, 4'b0000);
    ticks(1);
    check("R8 lag edge1 sync", {3'b000, sync_o[0]}, 4'b0000);
    ticks(1);
    check("R8 lag edge2 sync", {3'b000, sync_o[0]}, 4'b0001);

    // R6 enable gating
    wr(4'd3, 8'h02);
    check("R6 disabled async", {3'b000, async_o[0]}, 4'b0000);
    ticks(2);
    check("R6 disabled sync", {3'b000, sync_o[0]}, 4'b0000);

    // R4 R5 registered mode on system clock
    wr(4'd0, 8'h00);
    wr(4'd3, 8'h01);
    ticks(1);
    wr(4'd0, 8'hFF);
    check("R4 register lags table", {3'b000, async_o[0]}, 4'b0000);
    ticks(1);
    check("R5 sysclk capture", {3'b000, async_o[0]}, 4'b0001);

    // R7 clear
    wr(4'd3, 8'h21);
    check("R7 before clear acts", {3'b000, async_o[0]}, 4'b0001);
    ticks(1);
    check("R7 cleared", {3'b000, async_o[0]}, 4'b0000);
    ticks(1);
    check("R7 stays cleared", {3'b000, async_o[0]}, 4'b0000);

    // R5 ext clock, rising
    wr(4'd0, 8'h00);
    wr(4'd3, 8'h01);
    ticks(1);
    wr(4'd3, 8'h11);
    wr(4'd0, 8'hFF);
    ticks(2);
    check("R5 no ext edge holds", {3'b000, async_o[0]}, 4'b0000);
    ext_clk = 1'b1;
    ticks(1);
    check("R5 rising ext edge", {3'b000, async_o[0]}, 4'b0001);
    // falling polarity
    wr(4'd3, 8'h15);
    wr(4'd0, 8'h00);
    ticks(2);
    check("R5 falling mode idle holds", {3'b000, async_o[0]}, 4'b0001);
    ext_clk = 1'b0;
    ticks(1);
    check("R5 falling ext edge", {3'b000, async_o[0]}, 4'b0000);
    wr(4'd0, 8'hFF);
    ext_clk = 1'b1;
    ticks(2);
    check("R5 rising ignored in falling mode", {3'b000, async_o[0]}, 4'b0000);
    ext_clk = 1'b0;

    // R11 set/reset latch: cell 0 forwards reset (ext1), cell 1 latch
    ext = '0;
    wr(4'd1, 8'd5);
    wr(4'd0, 8'hF0);
    wr(4'd3, 8'h03);
    wr(4'd5, 8'd4);        // A = set (ext0)
    wr(4'd6, 8'd1);        // B = own output (code 1)
    wr(4'd4, 8'h74);
    wr(4'd7, 8'h03);
    ext[1] = 1'b1; #1;
    check("R11 reset only", {3'b000, async_o[1]}, 4'b0000);
    ext[1] = 1'b0; #1;
    check("R11 hold low", {3'b000, async_o[1]}, 4'b0000);
    ext[0] = 1'b1; #1;
    check("R11 set only", {3'b000, async_o[1]}, 4'b0001);
    ext[0] = 1'b0; #1;
    check("R11 R3 hold high", {3'b000, async_o[1]}, 4'b0001);
    ticks(3);
    check("R11 hold high over edges", {3'b000, async_o[1]}, 4'b0001);
    ext[1] = 1'b1; #1;
    check("R11 R3 reset via carry", {3'b000, async_o[1]}, 4'b0000);
    ext[1] = 1'b0;

    // R10 reset clears configuration
    ticks(1);
    rst = 1'b1;
    ticks(2);
    rst = 1'b0;
    ext[0] = 1'b1;
    ticks(2);
    check("R10 config cleared async", async_o, 4'b0000);
    check("R10 config cleared sync", sync_o, 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule